// File: doc/BRIEF.md
# Encoded-Ratio Controller Clock Divider

This block derives a controller clock from a fast core clock. A three-bit code chooses one of eight division ratios from an irregular set (1, 2, 4, 6, 8, 16, 24, 32). Every ratio other than 1 is even and is produced with a 50% duty cycle. Code 0 passes the core clock straight through. A separate bypass select can route an externally supplied clock to the output in place of the divided core clock. A clock enable gates whichever source is selected.

A dedicated divider reset holds the counter idle. While it is held, the ratio code is captured. Counting begins once it is released. A ratio change made while the divider runs is applied only where the current output period ends, so the output never carries a shortened high phase. Both the source switch and the enable gate are glitch-free. The old source is dropped only while it is low, and the new one is taken only after the old one is known to be off. The code and enable are registered to readback outputs, so configuration software can confirm what the block accepted.

Top module: `ctrl_clk_divider`

## Requirements
- R1: With bypass off and enable high, the output period equals the core period times the ratio for the code. The codes map 0→1, 1→2, 2→4, 3→6, 4→8, 5→16, 6→24 and 7→32.
- R2: While `div_rst` is high, the divided path produces no rising edges. After release, the first output rise comes on the (ratio/2)-th core rising edge, counting the first edge that samples `div_rst` low as edge one.
- R3: For even ratios the output high time is ratio/2 core periods. For code 0 the output follows the core clock, high for half a core period.
- R4: When `clk_en` is low, the output stays low and shows no rising edges, whether the source is the divided core clock or the external clock.
- R5: With `ext_sel` at 1, the output period equals the external clock period. With `ext_sel` at 0, it returns to the divided core clock.
- R6: On each core rising edge out of reset, `sel_rb` and `en_rb` capture `ratio_sel` and `clk_en` unchanged.
- R7: A code change while `div_rst` is low takes effect only at the end of the current full output period. No high pulse is shorter than the smaller of the old and new high times.
- R8: During a source switch the output stays low between sources. The two sources are never gated on together. No high pulse is shorter than the smaller of the two sources' high times.
- R9: While `rst_n` is low, the output is low and both readbacks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Fast core clock that is divided |
| ext_clk | input | 1 | Externally supplied clock for bypass |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ratio_sel | input | 3 | Division ratio code |
| div_rst | input | 1 | Holds the divider counter in reset |
| clk_en | input | 1 | Gates the output clock |
| ext_sel | input | 1 | 0 = divided core clock, 1 = external clock |
| ctrl_clk | output | 1 | Controller clock output |
| sel_rb | output | 3 | Registered readback of the ratio code |
| en_rb | output | 1 | Registered readback of the enable |

## Verification
A ratio change and a source switch can land in the same core cycle. The bench provokes this by changing the code from ratio 4 to ratio 6 and raising `ext_sel` on one cycle. It then watches every high phase of the output. The shortest high phase seen must be no shorter than the external clock's high time, which is the smaller of the sources involved. Once the output settles, it must show the external period. When bypass is later dropped, the output must settle to the new ratio. Runs that change only the code, only the enable, or only the source check the same minimum-pulse rule on their own.

// File: rtl/ckdiv_pkg.sv
`timescale 1ns/1ps
package ckdiv_pkg;
    localparam int SEL_W = 3;
    localparam int CNT_W = 5;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // Core cycles per output half-period for each code (code 0 is passthrough).
    function automatic cnt_t half_count(input sel_t code);
        cnt_t h;
        case (code)
            sel_t'(0), sel_t'(1): h = cnt_t'(1);
            sel_t'(2):            h = cnt_t'(2);
            sel_t'(3):            h = cnt_t'(3);
            sel_t'(4):            h = cnt_t'(4);
            sel_t'(5):            h = cnt_t'(8);
            sel_t'(6):            h = cnt_t'(12);
            default:              h = cnt_t'(16);
        endcase
        return h;
    endfunction

    function automatic logic is_pass(input sel_t code);
        return (code == '0);
    endfunction

    typedef struct packed {
        cnt_t cnt;
        logic div;
        sel_t act;
    } div_state_t;

    typedef struct packed {
        logic want;
        logic peer1;
        logic peer2;
        logic on;
    } core_gate_t;

    typedef struct packed {
        logic want1;
        logic want2;
        logic peer1;
        logic peer2;
        logic on;
    } ext_gate_t;

    typedef struct packed {
        sel_t sel;
        logic en;
    } readback_t;
endpackage

// File: rtl/ckdiv_counter.sv
`timescale 1ns/1ps
module ckdiv_counter
    import ckdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic div_rst,
    input  sel_t sel_in,
    output logic src_clk,
    output logic src_low
);
    div_state_t st_d, st_q;
    logic       pass_d, pass_q;
    cnt_t       half;
    logic       tc;

    always_comb begin
        half   = half_count(st_q.act);
        tc     = (st_q.cnt == half - cnt_t'(1));
        st_d   = st_q;
        if (div_rst) begin
            st_d.cnt = '0;
            st_d.div = 1'b0;
            st_d.act = sel_in;
        end else if (is_pass(st_q.act)) begin
            st_d.cnt = '0;
            st_d.div = 1'b0;
            st_d.act = sel_in;
        end else if (tc) begin
            st_d.cnt = '0;
            st_d.div = !st_q.div;
            if (st_q.div) begin
                st_d.act = sel_in;
            end
        end else begin
            st_d.cnt = st_q.cnt + cnt_t'(1);
        end
        pass_d = is_pass(st_q.act) && !div_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Passthrough select changes only while the core clock is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
        end else begin
            pass_q <= pass_d;
        end
    end

    assign src_clk = pass_q ? clk : st_q.div;
    assign src_low = pass_q | !st_q.div;

    AST_RST_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |=> !st_q.div); // R2

    AST_SEL_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_rst && !is_pass(st_q.act) && !(tc && st_q.div)) |=> $stable(st_q.act)); // R7

    AST_PASS_NO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        is_pass(st_q.act) |=> !st_q.div); // R3
endmodule

// File: rtl/ckdiv_switch.sv
`timescale 1ns/1ps
module ckdiv_switch
    import ckdiv_pkg::*;
(
    input  logic core_clk,
    input  logic ext_clk,
    input  logic rst_n,
    input  logic src_clk,
    input  logic src_low,
    input  logic clk_en,
    input  logic ext_sel,
    output logic clk_out
);
    core_gate_t core_d, core_q;
    ext_gate_t  ext_d, ext_q;

    always_comb begin
        core_d       = core_q;
        core_d.want  = clk_en && !ext_sel;
        core_d.peer1 = ext_q.on;
        core_d.peer2 = core_q.peer1;
        if (src_low) begin
            core_d.on = core_q.want && !core_q.peer2;
        end

        ext_d       = ext_q;
        ext_d.want1 = clk_en && ext_sel;
        ext_d.want2 = ext_q.want1;
        ext_d.peer1 = core_q.on;
        ext_d.peer2 = ext_q.peer1;
        ext_d.on    = ext_q.want2 && !ext_q.peer2;
    end

    always_ff @(negedge core_clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    always_ff @(negedge ext_clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else begin
            ext_q <= ext_d;
        end
    end

    assign clk_out = (src_clk & core_q.on) | (ext_clk & ext_q.on);

    AST_SINGLE_SOURCE: assert property (@(posedge core_clk) disable iff (!rst_n)
        !(core_q.on && ext_q.on)); // R8

    AST_EXT_GATED_OFF: assert property (@(posedge ext_clk) disable iff (!rst_n)
        !ext_q.want2 |=> !ext_q.on); // R4
endmodule

// File: rtl/ctrl_clk_divider.sv
`timescale 1ns/1ps
module ctrl_clk_divider
    import ckdiv_pkg::*;
(
    input  logic       core_clk,
    input  logic       ext_clk,
    input  logic       rst_n,
    input  logic [2:0] ratio_sel,
    input  logic       div_rst,
    input  logic       clk_en,
    input  logic       ext_sel,
    output logic       ctrl_clk,
    output logic [2:0] sel_rb,
    output logic       en_rb
);
    logic      src_clk;
    logic      src_low;
    readback_t rb_d, rb_q;

    ckdiv_counter u_counter (
        .clk     (core_clk),
        .rst_n   (rst_n),
        .div_rst (div_rst),
        .sel_in  (ratio_sel),
        .src_clk (src_clk),
        .src_low (src_low)
    );

    ckdiv_switch u_switch (
        .core_clk (core_clk),
        .ext_clk  (ext_clk),
        .rst_n    (rst_n),
        .src_clk  (src_clk),
        .src_low  (src_low),
        .clk_en   (clk_en),
        .ext_sel  (ext_sel),
        .clk_out  (ctrl_clk)
    );

    always_comb begin
        rb_d.sel = ratio_sel;
        rb_d.en  = clk_en;
    end

    always_ff @(posedge core_clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q <= '0;
        end else begin
            rb_q <= rb_d;
        end
    end

    assign sel_rb = rb_q.sel;
    assign en_rb  = rb_q.en;

    AST_READBACK_MATCH: assert property (@(posedge core_clk) disable iff (!rst_n)
        $past(rst_n) |-> (sel_rb == $past(ratio_sel) && en_rb == $past(clk_en))); // R6
endmodule

// File: tb/ctrl_clk_divider_test.sv
`timescale 1ns/1ps
module ctrl_clk_divider_test;
    logic       core_clk  = 1'b0;
    logic       ext_clk   = 1'b0;
    logic       rst_n     = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic       div_rst   = 1'b1;
    logic       clk_en    = 1'b0;
    logic       ext_sel   = 1'b0;
    logic       ctrl_clk;
    logic [2:0] sel_rb;
    logic       en_rb;

    int  vectors     = 0;
    int  miscompares = 0;
    int  rises       = 0;
    real last_rise   = 0.0;
    real min_high    = 1.0e9;

    localparam real CORE_T = 4.0;
    localparam real EXT_T  = 14.0;

    always #2 core_clk = ~core_clk;
    always #7 ext_clk  = ~ext_clk;

    ctrl_clk_divider uut (
        .core_clk  (core_clk),
        .ext_clk   (ext_clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .div_rst   (div_rst),
        .clk_en    (clk_en),
        .ext_sel   (ext_sel),
        .ctrl_clk  (ctrl_clk),
        .sel_rb    (sel_rb),
        .en_rb     (en_rb)
    );

    always @(posedge ctrl_clk) begin
        rises     = rises + 1;
        last_rise = $realtime;
    end

    always @(negedge ctrl_clk) begin
        if ($realtime - last_rise < min_high) min_high = $realtime - last_rise;
    end

    function automatic int ratio_of(input int code);
        if (code == 0) return 1;
        if (code <= 4) return 2 * code;
        return 8 * (code - 3);
    endfunction

    task automatic chk_real(input string req, input string what, input real act, input real exp);
        vectors++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            miscompares++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    task automatic chk_min(input string req, input string what, input real act, input real lim);
        vectors++;
        if (act < lim - 0.01) begin
            miscompares++;
            $display("FAIL %s %s: actual %0.3f expected at least %0.3f", req, what, act, lim);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge core_clk);
        #1;
    endtask

    task automatic measure(output real per, output real hi);
        real t0, t1, t2;
        @(posedge ctrl_clk); t0 = $realtime;
        @(posedge ctrl_clk); t1 = $realtime;
        @(negedge ctrl_clk); t2 = $realtime;
        per = t1 - t0;
        hi  = t2 - t1;
        cyc(1);
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        real per, hi;
        // R9: reset state
        ratio_sel = 3'd5;
        clk_en    = 1'b1;
        div_rst   = 1'b0;
        cyc(5);
        chk_int("R9", "ctrl_clk in reset", int'(ctrl_clk), 0);
        chk_int("R9", "sel_rb in reset", int'(sel_rb), 0);
        chk_int("R9", "en_rb in reset", int'(en_rb), 0);
        rst_n = 1'b1;
        cyc(2);

        // R1 R3 R6: sweep every code
        for (int code = 0; code < 8; code++) begin
            div_rst   = 1'b1;
            ratio_sel = 3'(code);
            clk_en    = 1'b1;
            ext_sel   = 1'b0;
            cyc(4);
            div_rst = 1'b0;
            cyc(3 * ratio_of(code) + 12);
            measure(per, hi);
            chk_real("R1", $sformatf("period code %0d", code), per, CORE_T * ratio_of(code));
            chk_real("R3", $sformatf("high time code %0d", code), hi, CORE_T * ratio_of(code) / 2.0);
            chk_int("R6", $sformatf("sel_rb code %0d", code), int'(sel_rb), code);
            chk_int("R6", "en_rb high", int'(en_rb), 1);
        end

        // R2: divider reset hold and start latency (ratio 6)
        ratio_sel = 3'd3;
        div_rst   = 1'b1;
        cyc(10);
        rises = 0;
        cyc(40);
        chk_int("R2", "rises while divider reset", rises, 0);
        div_rst = 1'b0;
        rises   = 0;
        cyc(2);
        chk_int("R2", "no rise before ratio/2 edges", rises, 0);
        cyc(2);
        chk_int("R2", "first rise after ratio/2 edges", rises, 1);
        cyc(30);
        measure(per, hi);
        chk_real("R2", "period after release", per, 24.0);

        // R4: enable gating on divided path (ratio 2)
        ratio_sel = 3'd1;
        cyc(40);
        clk_en = 1'b0;
        cyc(10);
        rises = 0;
        cyc(50);
        chk_int("R4", "rises with enable low", rises, 0);
        chk_int("R6", "en_rb low", int'(en_rb), 0);
        clk_en = 1'b1;
        cyc(20);
        measure(per, hi);
        chk_real("R4", "period after enable", per, 8.0);

        // R5 R8: bypass switching from ratio 4
        ratio_sel = 3'd2;
        cyc(40);
        min_high = 1.0e9;
        ext_sel  = 1'b1;
        cyc(60);
        measure(per, hi);
        chk_real("R5", "bypass period", per, EXT_T);
        chk_real("R5", "bypass high time", hi, EXT_T / 2.0);
        chk_min("R8", "min high into bypass", min_high, EXT_T / 2.0);
        clk_en = 1'b0;
        cyc(10);
        rises = 0;
        cyc(60);
        chk_int("R4", "rises with bypass and enable low", rises, 0);
        min_high = 1.0e9;
        clk_en   = 1'b1;
        ext_sel  = 1'b0;
        cyc(60);
        measure(per, hi);
        chk_real("R5", "period after leaving bypass", per, 16.0);
        chk_min("R8", "min high leaving bypass", min_high, EXT_T / 2.0);

        // R7: on-the-fly code changes
        min_high  = 1.0e9;
        ratio_sel = 3'd4;
        cyc(60);
        chk_min("R7", "min high ratio 4 to 8", min_high, 8.0);
        measure(per, hi);
        chk_real("R7", "period after 4 to 8", per, 32.0);
        ratio_sel = 3'd5;
        cyc(100);
        min_high  = 1.0e9;
        ratio_sel = 3'd1;
        cyc(60);
        chk_min("R7", "min high ratio 16 to 2", min_high, 4.0);
        measure(per, hi);
        chk_real("R7", "period after 16 to 2", per, 8.0);
        min_high  = 1.0e9;
        ratio_sel = 3'd0;
        cyc(30);
        chk_min("R7", "min high ratio 2 to passthrough", min_high, 2.0);
        measure(per, hi);
        chk_real("R7", "period after 2 to 1", per, 4.0);
        min_high  = 1.0e9;
        ratio_sel = 3'd2;
        cyc(40);
        chk_min("R7", "min high passthrough to 4", min_high, 2.0);
        measure(per, hi);
        chk_real("R7", "period after 1 to 4", per, 16.0);

        // R8: code change and bypass switch in the same cycle
        min_high  = 1.0e9;
        ratio_sel = 3'd3;
        ext_sel   = 1'b1;
        cyc(80);
        chk_min("R8", "min high with concurrent change", min_high, EXT_T / 2.0);
        measure(per, hi);
        chk_real("R5", "bypass period after concurrent change", per, EXT_T);
        ext_sel = 1'b0;
        cyc(80);
        measure(per, hi);
        chk_real("R1", "ratio 6 after bypass drop", per, 24.0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule